// File: doc/BRIEF.md
# Four-Way Interleaved Line-Fill Memory

This block models a main memory that answers cache line fills with exact cycle timing. The storage is split into four word-wide banks. Consecutive word addresses rotate across the banks, so each bank holds every fourth word. A fill request carries the start address of an eight-word line. All four banks then begin their first access in the same cycle. When a bank's access finishes, it parks the word in a private buffer register. The buffered words stream to the requester one per cycle. While they drain, each bank already runs its second access, so the second group of four words is ready as soon as the first group has gone.

A first access in a bank takes eight cycles and a following access in the same bank takes four. The address transfer takes one cycle. With these costs a full line arrives 17 cycles after the request. A single bank with the same costs would need 38 cycles. The banks are synchronous register arrays. They are loaded through a plain word write port before fills are issued.

Top module: `ilv_fill_mem`

## Requirements
- R1: While and after synchronous reset, with no request, `rd_valid` and `rd_done` are low.
- R2: A fill returns the eight words stored at line base addresses base+0 through base+7, in that ascending order, one per cycle.
- R3: Suppose `req` is sampled high in cycle c while the block is idle. Then `rd_valid` is high in cycles c+9 through c+16 and in no other cycle of that fill.
- R4: `rd_done` is a single-cycle pulse in cycle c+17, and `rd_valid` is low in that cycle.
- R5: The three low bits of `req_addr` are ignored. The line base is `req_addr` with those bits cleared.
- R6: A `req` raised while a fill is in progress (cycles c+1 through c+16) is ignored. The running fill's data and timing are unchanged, and no second fill follows.
- R7: A request made in the cycle where `rd_done` is high is accepted. Its fill follows the timing of R3 and R4, measured from that cycle.
- R8: When `wr_en` is high, `wr_data` is stored at word `wr_addr`. Bits [1:0] select the bank and the upper bits select the row. A later fill of that line returns the new value.
- R9: A bank's buffer register keeps its first word until that word has been sent. The second access of the bank never overwrites it early.
- R10: `rd_data` is zero in every cycle where `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Preload write strobe |
| wr_addr | input | ADDR_W | Preload word address |
| wr_data | input | DATA_W | Preload word value |
| req | input | 1 | Fill request strobe |
| req_addr | input | ADDR_W | Line start word address (low three bits ignored) |
| rd_valid | output | 1 | Word on `rd_data` is valid |
| rd_data | output | DATA_W | Returned word |
| rd_done | output | 1 | One-cycle pulse after the last word of a fill |

## Verification
The bench fills every line of the store. It compares each cycle's valid, done and data against windows computed from the request cycle, so a design off by one cycle in the address phase, in the first latency or in the second latency shows up at once. It also checks words four to seven against their own addresses. A bank that overwrote its buffer early would return the second-group word in place of the first-group word. A request issued in the done cycle catches a controller that is still busy there. A misaligned address catches a design that fails to clear the offset bits. An intruding mid-fill request catches a design that restarts or queues a fill.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

    typedef enum logic {
        BK_IDLE   = 1'b0,
        BK_ACCESS = 1'b1
    } bank_state_e;

    typedef enum logic {
        FS_IDLE = 1'b0,
        FS_FILL = 1'b1
    } fill_state_e;

    function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ilv_bank.sv
module ilv_bank
    import ilv_pkg::*;
#(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned ROW_W     = 6,
    parameter int unsigned FIRST_LAT = 8,
    parameter int unsigned NEXT_LAT  = 4,
    parameter int unsigned ACCESSES  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ROW_W-1:0]  wr_row,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              start,
    input  logic [ROW_W-1:0]  start_row,
    input  logic              drain,
    output logic [DATA_W-1:0] dbr_q,
    output logic              dbr_full
);
    localparam int unsigned DEPTH  = 1 << ROW_W;
    localparam int unsigned CNT_W  = $clog2(max_of(FIRST_LAT, NEXT_LAT));
    localparam int unsigned LEFT_W = $clog2(ACCESSES + 1);

    logic [DATA_W-1:0] mem [DEPTH];
    bank_state_e       state;
    logic [CNT_W-1:0]  cnt;
    logic [ROW_W-1:0]  row;
    logic [LEFT_W-1:0] left;
    logic              can_load;
    logic              load;

    assign can_load = !dbr_full || drain;
    assign load     = (state == BK_ACCESS) && (cnt == '0) && can_load;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_row] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= BK_IDLE;
            cnt      <= '0;
            row      <= '0;
            left     <= '0;
            dbr_q    <= '0;
            dbr_full <= 1'b0;
        end else begin
            if (drain) begin
                dbr_full <= 1'b0;
            end
            case (state)
                BK_IDLE: begin
                    if (start) begin
                        state <= BK_ACCESS;
                        cnt   <= CNT_W'(FIRST_LAT - 1);
                        row   <= start_row;
                        left  <= LEFT_W'(ACCESSES);
                    end
                end
                BK_ACCESS: begin
                    if (cnt != '0) begin
                        cnt <= cnt - 1'b1;
                    end else if (load) begin
                        dbr_q    <= mem[row];
                        dbr_full <= 1'b1;
                        if (left > LEFT_W'(1)) begin
                            left <= left - 1'b1;
                            row  <= row + 1'b1;
                            cnt  <= CNT_W'(NEXT_LAT - 1);
                        end else begin
                            left  <= '0;
                            state <= BK_IDLE;
                        end
                    end
                end
                default: state <= BK_IDLE;
            endcase
        end
    end

    // R9: an unsent word stays put
    a_r9_no_clobber: assert property (@(posedge clk) disable iff (rst)
        (dbr_full && !drain) |=> (dbr_full && $stable(dbr_q)));

    // R9: only a full buffer is ever drained
    a_r9_drain_full: assert property (@(posedge clk) disable iff (rst)
        drain |-> dbr_full);

endmodule

// File: rtl/ilv_fill_ctrl.sv
module ilv_fill_ctrl
    import ilv_pkg::*;
#(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned NUM_BANKS  = 4,
    parameter int unsigned LINE_WORDS = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         req,
    input  logic [ADDR_W-1:0]            req_addr,
    input  logic [NUM_BANKS-1:0]         bank_full,
    output logic                         bank_start,
    output logic [ADDR_W-$clog2(NUM_BANKS)-1:0] start_row,
    output logic [NUM_BANKS-1:0]         drain,
    output logic [$clog2(NUM_BANKS)-1:0] sel,
    output logic                         rd_valid,
    output logic                         rd_done
);
    localparam int unsigned BANK_W = $clog2(NUM_BANKS);
    localparam int unsigned OFF_W  = $clog2(LINE_WORDS);

    fill_state_e      state;
    logic [OFF_W-1:0] ptr;
    logic             last;

    assign bank_start = (state == FS_IDLE) && req;
    assign start_row  = {req_addr[ADDR_W-1:OFF_W], {(OFF_W-BANK_W){1'b0}}};
    assign sel        = ptr[BANK_W-1:0];
    assign rd_valid   = (state == FS_FILL) && bank_full[sel];
    assign drain      = rd_valid ? (NUM_BANKS'(1) << sel) : '0;
    assign last       = (ptr == OFF_W'(LINE_WORDS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= FS_IDLE;
            ptr     <= '0;
            rd_done <= 1'b0;
        end else begin
            rd_done <= 1'b0;
            case (state)
                FS_IDLE: begin
                    if (req) begin
                        state <= FS_FILL;
                        ptr   <= '0;
                    end
                end
                FS_FILL: begin
                    if (rd_valid) begin
                        ptr <= ptr + 1'b1;
                        if (last) begin
                            state   <= FS_IDLE;
                            rd_done <= 1'b1;
                        end
                    end
                end
                default: state <= FS_IDLE;
            endcase
        end
    end

    // R4: done lasts one cycle
    a_r4_done_pulse: assert property (@(posedge clk) disable iff (rst)
        rd_done |=> !rd_done);

    // R4: done directly follows the last word
    a_r4_done_after_word: assert property (@(posedge clk) disable iff (rst)
        rd_done |-> ($past(rd_valid) && !rd_valid));

    // R3: once streaming, words keep coming until the line ends
    a_r3_contiguous: assert property (@(posedge clk) disable iff (rst)
        ($past(rd_valid) && state == FS_FILL) |-> rd_valid);

    // R6: no bank restart while a fill runs
    a_r6_ignore_busy: assert property (@(posedge clk) disable iff (rst)
        (state == FS_FILL) |-> !bank_start);

endmodule

// File: rtl/ilv_fill_mem.sv
module ilv_fill_mem
    import ilv_pkg::*;
#(
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned NUM_BANKS  = 4,
    parameter int unsigned LINE_WORDS = 8,
    parameter int unsigned FIRST_LAT  = 8,
    parameter int unsigned NEXT_LAT   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_done
);
    localparam int unsigned BANK_W   = $clog2(NUM_BANKS);
    localparam int unsigned ROW_W    = ADDR_W - BANK_W;
    localparam int unsigned ACCESSES = LINE_WORDS / NUM_BANKS;

    logic [NUM_BANKS-1:0] bank_full;
    logic [NUM_BANKS-1:0] drain;
    logic [DATA_W-1:0]    dbr [NUM_BANKS];
    logic                 bank_start;
    logic [ROW_W-1:0]     start_row;
    logic [BANK_W-1:0]    sel;
    logic [BANK_W-1:0]    wr_bank;
    logic [ROW_W-1:0]     wr_row;

    assign wr_bank = wr_addr[BANK_W-1:0];
    assign wr_row  = wr_addr[ADDR_W-1:BANK_W];

    ilv_fill_ctrl #(
        .ADDR_W     (ADDR_W),
        .NUM_BANKS  (NUM_BANKS),
        .LINE_WORDS (LINE_WORDS)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .req_addr   (req_addr),
        .bank_full  (bank_full),
        .bank_start (bank_start),
        .start_row  (start_row),
        .drain      (drain),
        .sel        (sel),
        .rd_valid   (rd_valid),
        .rd_done    (rd_done)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        ilv_bank #(
            .DATA_W    (DATA_W),
            .ROW_W     (ROW_W),
            .FIRST_LAT (FIRST_LAT),
            .NEXT_LAT  (NEXT_LAT),
            .ACCESSES  (ACCESSES)
        ) u_bank (
            .clk       (clk),
            .rst       (rst),
            .wr_en     (wr_en && (wr_bank == BANK_W'(b))),
            .wr_row    (wr_row),
            .wr_data   (wr_data),
            .start     (bank_start),
            .start_row (start_row),
            .drain     (drain[b]),
            .dbr_q     (dbr[b]),
            .dbr_full  (bank_full[b])
        );
    end

    assign rd_data = rd_valid ? dbr[sel] : '0;

    // R2: at most one bank hands over a word per cycle
    a_r2_one_drain: assert property (@(posedge clk) disable iff (rst)
        $onehot0(drain));

    // R10: idle data bus is zero
    a_r10_zero_idle: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |-> (rd_data == '0));

endmodule

// File: tb/ilv_fill_mem_tb.sv
`timescale 1ns/1ps
module ilv_fill_mem_tb;
    localparam int unsigned DW = 16;
    localparam int unsigned AW = 8;
    localparam int unsigned NW = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          req = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          rd_valid;
    logic [DW-1:0] rd_data;
    logic          rd_done;

    int n_run  = 0;
    int n_fail = 0;
    logic [DW-1:0] model [NW];

    always #2.5 clk = ~clk;

    ilv_fill_mem u_dut (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .req      (req),
        .req_addr (req_addr),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .rd_done  (rd_done)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int unsigned a, input int unsigned salt);
        return DW'((a * 40503 + salt * 977) ^ 16'h5A5A);
    endfunction

    task automatic write_word(input int unsigned a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        model[a] = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // One fill, optionally a mid-fill intrusion (R6) and a request in the done cycle (R7).
    task automatic do_fill(input int unsigned base, input int unsigned junk,
                           input bit intrude, input bit chain, input int unsigned base2);
        int unsigned kmax;
        kmax = chain ? 36 : 20;
        @(negedge clk);
        req = 1'b1; req_addr = AW'(base | junk);
        for (int unsigned k = 1; k <= kmax; k++) begin
            @(negedge clk);
            if (k == 1 || k == 4 || k == 18) req = 1'b0;
            if (intrude && k == 3) begin req = 1'b1; req_addr = AW'((base + 64) % NW); end
            begin
                int unsigned j;
                int unsigned lb;
                bit ev;
                bit ed;
                if (chain && k > 17) begin j = k - 17; lb = base2; end
                else begin j = k; lb = base; end
                ev = (j >= 9 && j <= 16);
                ed = (j == 17);
                chk(rd_valid == ev, $sformatf("R3 valid window k=%0d", k), 32'(rd_valid), 32'(ev));
                chk(rd_done == ed, $sformatf("R4 done pulse k=%0d", k), 32'(rd_done), 32'(ed));
                if (ev) begin
                    // R2 order; words 4..7 also prove R9 (first word held until sent)
                    chk(rd_data == model[lb + j - 9],
                        $sformatf("R2 R9 word %0d of line %0h", j - 9, lb),
                        32'(rd_data), 32'(model[lb + j - 9]));
                end else begin
                    chk(rd_data == '0, $sformatf("R10 idle data k=%0d", k), 32'(rd_data), 32'h0);
                end
            end
            if (chain && k == 17) begin req = 1'b1; req_addr = AW'(base2); end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(rd_valid == 1'b0, "R1 valid in reset", 32'(rd_valid), 32'h0);
        chk(rd_done == 1'b0, "R1 done in reset", 32'(rd_done), 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk(rd_valid == 1'b0, "R1 valid after reset", 32'(rd_valid), 32'h0);
        chk(rd_done == 1'b0, "R1 done after reset", 32'(rd_done), 32'h0);

        // R8 preload through the write port
        for (int unsigned a = 0; a < NW; a++) write_word(a, pat(a, 0));

        // sweep every line
        for (int unsigned l = 0; l < NW / 8; l++) do_fill(l * 8, 0, 1'b0, 1'b0, 0);

        // R5 offset bits ignored
        do_fill(8'h28, 5, 1'b0, 1'b0, 0);
        do_fill(8'hF0, 7, 1'b0, 1'b0, 0);

        // R6 mid-fill request ignored
        do_fill(8'h40, 0, 1'b1, 1'b0, 0);

        // R7 back-to-back
        do_fill(8'h10, 0, 1'b0, 1'b1, 8'hA8);
        do_fill(8'hF8, 3, 1'b0, 1'b1, 8'h00);

        // R8 overwrite one line, then fill it again
        for (int unsigned i = 0; i < 8; i++) write_word(8'h60 + i, pat(8'h60 + i, 7));
        do_fill(8'h60, 0, 1'b0, 1'b0, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule